// File: doc/BRIEF.md
# Write-Only Serial Configuration Register Slave

This block is the configuration port of a clock generator. It listens on a two-wire serial bus (I2C, standard mode) as a receive-only slave and fills a small bank of 8-bit control registers, whose values leave the block in parallel and drive the output-enable and mode logic next to it. Both bus wires are brought into a fast system clock domain through a synchronizer. Start and stop conditions are found there, and every bit is sampled on a rising edge of the serial clock.

The slave accepts block writes only. After the address it acknowledges two header bytes and throws their contents away. Data bytes then fill the registers, always beginning at register 0 and rising one register per byte. The host may end a transfer with a stop after any whole byte. A repeated start begins the header sequence again. Reads are not supported: an address byte with the read bit set gets no acknowledge. Register 0 carries the spread-spectrum enable in bit 3 and the enables of the two fixed 48 MHz outputs in bits 2 and 1. Its upper nibble and bit 0 are reserved, and the host writes them as 0.

Top module: `cfg_i2c_wr_slave`

## Requirements
- R1: After reset the registers hold 0x16, 0xFF, 0xFE, 0x00, 0x07, 0x00 for registers 0 to 5, and sda_oe is 0.
- R2: The only address byte acknowledged is 0xD2 (7-bit address 0x69, read/write bit 0). Any other address byte, 0xD3 included, gets no acknowledge. The slave then ignores the bus until the next start, and no register changes.
- R3: The two bytes that follow an accepted address are acknowledged, and their values change no register.
- R4: Data byte k (k = 0 to 5, counted from the first byte after the two header bytes) is acknowledged and written to register k. Bytes are received most significant bit first.
- R5: A stop after any complete byte ends the transfer. Registers written in that transfer keep their new values, and all other registers keep their previous values.
- R6: Data bytes beyond the sixth are acknowledged and stored nowhere.
- R7: A repeated start restarts the sequence. An address is expected next, then two header bytes, and the next data byte goes to register 0 again.
- R8: The slave pulls SDA low (sda_oe = 1) only during the acknowledge clock. It asserts sda_oe after the falling SCL edge that ends the eighth bit, keeps it stable while SCL is high, and releases it after the falling edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| cfg_regs | output | NREG*8 | Register k on bits [8k+7:8k] |

## Verification
The bench builds the block with its default parameters: six registers, two header bytes, address 0x69 and a two-stage synchronizer. With six registers, transfers of up to eight data bytes reach the overrun case. Short transfers reach stops after every byte count. The serial clock runs with a quarter-bit time of ten system clocks. That is long enough for the three-cycle synchronizer and event delay, and it keeps room between the DUT's release of the acknowledge and the host's next data bit.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RECV = 2'd1,
        PH_ACK  = 2'd2
    } rx_phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    function automatic logic [BYTE_W-1:0] reg_default(input int unsigned idx);
        case (idx)
            0:       return 8'h16;
            1:       return 8'hFF;
            2:       return 8'hFE;
            4:       return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import cfg_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;
    logic              scl_c;
    logic              sda_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_c = scl_q[STAGES-1];
    assign sda_c = sda_q[STAGES-1];

    always_comb begin
        evt.scl   = scl_c;
        evt.sda   = sda_c;
        evt.start = scl_c & scl_p & sda_p & ~sda_c;
        evt.stop  = scl_c & scl_p & ~sda_p & sda_c;
        evt.rise  = scl_c & ~scl_p;
        evt.fall  = ~scl_c & scl_p;
    end

endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         HDR_BYTES = 2,
    parameter int         NREG      = 6,
    localparam int        IW        = idx_width(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [IW-1:0]     wr_idx,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int IDX_MAX   = 1 + HDR_BYTES + NREG;
    localparam int BW        = $clog2(IDX_MAX + 1);
    localparam int DATA_BASE = 1 + HDR_BYTES;
    localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

    rx_phase_t         ph;
    logic [3:0]        bitc;
    logic [BW-1:0]     bidx;
    logic [BYTE_W-1:0] shreg;
    logic              in_data;
    logic [BW-1:0]     data_off;

    assign in_data  = (bidx >= BW'(DATA_BASE)) && (bidx < BW'(IDX_MAX));
    assign data_off = bidx - BW'(DATA_BASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            bitc    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt.start) begin
                ph     <= PH_RECV;
                bitc   <= '0;
                bidx   <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                ph     <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (ph)
                    PH_RECV: begin
                        if (evt.rise && bitc != 4'd8) begin
                            shreg <= {shreg[BYTE_W-2:0], evt.sda};
                            bitc  <= bitc + 4'd1;
                        end else if (evt.fall && bitc == 4'd8) begin
                            if (bidx == '0) begin
                                if (shreg == ADDR_BYTE) begin
                                    sda_oe <= 1'b1;
                                    ph     <= PH_ACK;
                                end else begin
                                    ph <= PH_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                ph     <= PH_ACK;
                                if (in_data) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= IW'(data_off);
                                    wr_data <= shreg;
                                end
                            end
                        end
                    end
                    PH_ACK: begin
                        if (evt.fall) begin
                            sda_oe <= 1'b0;
                            ph     <= PH_RECV;
                            bitc   <= '0;
                            if (bidx != BW'(IDX_MAX)) bidx <= bidx + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_i2c_pkg::*;
#(
    parameter int  NREG = 6,
    localparam int IW   = idx_width(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  logic [BYTE_W-1:0]      wr_data,
    output logic [NREG*BYTE_W-1:0] regs
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [BYTE_W-1:0] r;
        always_ff @(posedge clk) begin
            if (rst)
                r <= reg_default(g);
            else if (wr_en && wr_idx == IW'(g))
                r <= wr_data;
        end
        assign regs[g*BYTE_W +: BYTE_W] = r;
    end

endmodule

// File: rtl/cfg_i2c_wr_slave.sv
module cfg_i2c_wr_slave
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         HDR_BYTES   = 2,
    parameter int         NREG        = 6,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [NREG*BYTE_W-1:0] cfg_regs
);
    localparam int IW = idx_width(NREG);

    bus_evt_t          evt;
    logic              scl_lvl;
    logic              start_det;
    logic              stop_det;
    logic              wr_en;
    logic [IW-1:0]     wr_idx;
    logic [BYTE_W-1:0] wr_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    assign scl_lvl   = evt.scl;
    assign start_det = evt.start;
    assign stop_det  = evt.stop;

    i2c_rx_engine #(
        .DEV_ADDR  (DEV_ADDR),
        .HDR_BYTES (HDR_BYTES),
        .NREG      (NREG)
    ) u_rx (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    cfg_reg_bank #(.NREG(NREG)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs    (cfg_regs)
    );

endmodule

// File: rtl/cfg_i2c_wr_slave_chk.sv
module cfg_i2c_wr_slave_chk #(
    parameter int NREG = 6,
    parameter int IW   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_lvl,
    input logic              sda_oe,
    input logic              start_det,
    input logic              stop_det,
    input logic              wr_en,
    input logic [IW-1:0]     wr_idx,
    input logic [NREG*8-1:0] cfg_regs
);
    // R8
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

    // R5
    regs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(cfg_regs));

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ({1'b0, wr_idx} < (IW+1)'(NREG)));

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    // R7
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (!sda_oe && !wr_en));

endmodule

bind cfg_i2c_wr_slave cfg_i2c_wr_slave_chk #(.NREG(NREG), .IW(IW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (scl_lvl),
    .sda_oe    (sda_oe),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .cfg_regs  (cfg_regs)
);

// File: tb/tb_cfg_i2c_wr_slave.sv
`timescale 1ns/1ps
module tb_cfg_i2c_wr_slave;
    localparam int NREG = 6;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mscl = 1'b1;
    logic msda = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] cfg_regs;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] model [NREG];
    logic [7:0] payload [12];

    always #4 clk = ~clk;

    assign sda_line = msda & ~sda_oe;

    cfg_i2c_wr_slave dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (mscl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg_regs)
    );

    function automatic logic [7:0] dflt(input int i);
        case (i)
            0: return 8'h16;
            1: return 8'hFF;
            2: return 8'hFE;
            4: return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        msda = 1'b1; wq();
        mscl = 1'b1; wq();
        msda = 1'b0; wq();
        mscl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        msda = 1'b0; wq();
        mscl = 1'b1; wq();
        msda = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            msda = b[i]; wq();
            mscl = 1'b1; wq(); wq();
            mscl = 1'b0;
        end
        msda = 1'b1; wq();
        mscl = 1'b1; wq();
        acked = !sda_line;
        wq();
        mscl = 1'b0; wq();
        if (acked) chk("R8 ack released after ninth clock", sda_oe, 0);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++)
            chk(req, cfg_regs[i*8 +: 8], model[i]);
    endtask

    // Full write: address, two header bytes, n data bytes from payload.
    task automatic txn(input logic [7:0] addr, input int n, input bit do_stop);
        bit ack;
        bus_start();
        send_byte(addr, ack);
        if (addr == 8'hD2) begin
            chk("R2 address D2 acknowledged", ack, 1);
            send_byte(8'($urandom), ack);
            chk("R3 command byte acknowledged", ack, 1);
            send_byte(8'($urandom), ack);
            chk("R3 count byte acknowledged", ack, 1);
            for (int k = 0; k < n; k++) begin
                send_byte(payload[k], ack);
                if (k < NREG) begin
                    chk("R4 data byte acknowledged", ack, 1);
                    model[k] = payload[k];
                end else begin
                    chk("R6 extra byte acknowledged", ack, 1);
                end
            end
        end else begin
            chk("R2 foreign address not acknowledged", ack, 0);
            send_byte(8'h00, ack);
            chk("R2 idle after foreign address", ack, 0);
            send_byte(8'hA5, ack);
            chk("R2 idle after foreign address", ack, 0);
        end
        if (do_stop) bus_stop();
    endtask

    initial begin
        bit ack;
        void'($urandom(32'h0005EED1));
        for (int i = 0; i < NREG; i++) model[i] = dflt(i);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset values
        check_regs("R1 reset default");
        chk("R1 sda_oe idle", sda_oe, 0);

        // R4 full six-register write
        for (int k = 0; k < 6; k++) payload[k] = 8'h30 + 8'(k);
        txn(8'hD2, 6, 1'b1);
        check_regs("R4 full write");

        // R5 stop right after header: nothing changes
        txn(8'hD2, 0, 1'b1);
        check_regs("R5 stop after header");

        // R5 stop after two data bytes
        payload[0] = 8'hC1; payload[1] = 8'h5A;
        txn(8'hD2, 2, 1'b1);
        check_regs("R5 partial write");

        // R2 read address and wrong address
        txn(8'hD3, 0, 1'b1);
        check_regs("R2 read request ignored");
        txn(8'hA4, 0, 1'b1);
        check_regs("R2 foreign address ignored");

        // R6 overrun with eight data bytes
        for (int k = 0; k < 8; k++) payload[k] = 8'h90 + 8'(k);
        txn(8'hD2, 8, 1'b1);
        check_regs("R6 overrun not stored");

        // R7 repeated start: restart header, next data goes to register 0
        payload[0] = 8'h11;
        txn(8'hD2, 1, 1'b0);
        payload[0] = 8'h22; payload[1] = 8'h33;
        txn(8'hD2, 2, 1'b1);
        check_regs("R7 repeated start");

        // R7 repeated start after address and one header byte
        bus_start();
        send_byte(8'hD2, ack);
        chk("R7 address acknowledged", ack, 1);
        send_byte(8'h00, ack);
        payload[0] = 8'h44;
        txn(8'hD2, 1, 1'b1);
        check_regs("R7 restart mid header");

        // constrained random transfers
        for (int t = 0; t < 16; t++) begin
            int n;
            int sel;
            n   = int'($urandom_range(0, 8));
            sel = int'($urandom_range(0, 5));
            for (int k = 0; k < 12; k++) payload[k] = 8'($urandom);
            if (sel == 0) txn(8'hD3, 0, 1'b1);
            else if (sel == 1) txn({7'($urandom_range(0, 127)) ^ 7'h00, 1'b0} == 8'hD2 ? 8'hD0 : {7'($urandom_range(0, 127)), 1'b0}, 0, 1'b1);
            else txn(8'hD2, n, 1'b1);
            check_regs("R5 random transfer");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule